// File: doc/BRIEF.md
# Pulse-Swallow Dual-Modulus Frequency Divider

This block divides a fast clock by a programmable integer ratio and emits one pulse per division cycle, intended to drive one input of a phase/frequency detector. Internally a dual-modulus prescaler counts either 8 or 9 input clocks per period. A 3-bit swallow count holds the prescaler at 9 for the first few periods of each cycle. An 11-bit main count sets how many prescaler periods make up one output cycle. Together they give a ratio of 8·M + A.

The 14-bit ratio word is a static, level-sensitive input and is not registered at the edge of the block. The divider reads it only when a new division cycle starts. A word that the swallow scheme cannot realise raises a combinational flag. While that flag is high the divider stays parked and the output stays low.

Top module: `pswallow_div`

## Requirements
- R1: With M = ratio_word[13:3] and A = ratio_word[2:0], consecutive rising edges of pulse_out are exactly 8·M + A clock cycles apart. During each cycle the prescaler runs A periods of 9 clocks and then M − A periods of 8 clocks.
- R2: Each output pulse stays high for exactly 8 consecutive clock cycles, which is one divide-by-8 prescaler period.
- R3: The first edge with rst low loads the counters from ratio_word without producing a pulse. pulse_out first rises one full division cycle (8·M + A clocks) after that edge, so it is sampled high on the (8·M + A + 1)-th edge after reset is released.
- R4: rst is synchronous and active high. At the first edge where it is sampled high, both counters, the prescaler and the output are cleared, and pulse_out stays low while rst is held.
- R5: All ratios from 56 to 16383 are accepted. An all-ones word (the state of inputs left undriven) divides by 16383.
- R6: ratio_bad is high, combinationally from ratio_word, whenever 8·M + A < 56 or M < A.
- R7: At the first edge where ratio_bad is high, the divider parks and pulse_out goes low, even if a pulse is in progress. No pulse appears while the word stays invalid.
- R8: A change of ratio_word in the middle of a cycle does not alter that cycle. The new ratio applies from the next cycle boundary.
- R9: When the word becomes valid again after parking, the first edge that sees it loads the counters. The first pulse then follows one full division cycle later, with the same timing as after reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast input clock being divided |
| rst | input | 1 | Synchronous active-high reset |
| ratio_word | input | 14 | Static ratio: [13:3] main count M, [2:0] swallow count A |
| pulse_out | output | 1 | One 8-clock pulse per division cycle |
| ratio_bad | output | 1 | High while ratio_word cannot be realised |

## Verification
Two situations are hard to reach from the ports: a ratio change arriving in the middle of a running cycle, and an invalid word cutting into a pulse that is already high. The bench first locks onto a pulse rising edge, then waits a known number of clocks before changing the word. For the mid-cycle change it requires the gap from the old pulse to the next one to equal the old ratio, and the gap after that to equal the new one. For the invalid-word case it applies the bad word during the third high cycle of a pulse. It then requires the output to fall at the next edge, stay low, and resume with reset-like timing once a valid word returns.

// File: rtl/psd_pkg.sv
package psd_pkg;
    // Prescaler base modulus; the alternate modulus is one higher.
    localparam int unsigned PRE_MOD   = 8;
    localparam int unsigned SWALLOW_W = $clog2(PRE_MOD);
    localparam int unsigned MAIN_W    = 11;
    localparam int unsigned WORD_W    = MAIN_W + SWALLOW_W;
    // Smallest ratio reachable with every integer above it.
    localparam int unsigned MIN_RATIO = PRE_MOD * (PRE_MOD - 1);
    localparam int unsigned PULSE_LEN = PRE_MOD;
endpackage

// File: rtl/psd_ratio_check.sv
module psd_ratio_check
    import psd_pkg::*;
#(
    parameter int unsigned MOD = PRE_MOD,
    parameter int unsigned AW  = SWALLOW_W,
    parameter int unsigned MW  = MAIN_W
) (
    input  logic [MW+AW-1:0] word,
    output logic [MW-1:0]    main_val,
    output logic [AW-1:0]    swallow_val,
    output logic             bad
);
    localparam int unsigned WW     = MW + AW;
    localparam int unsigned LOWEST = MOD * (MOD - 1);

    logic [WW:0] ratio;
    logic        too_small;
    logic        short_main;

    always_comb begin
        main_val    = word[WW-1:AW];
        swallow_val = word[AW-1:0];
        ratio       = (WW+1)'(main_val) * (WW+1)'(MOD) + (WW+1)'(swallow_val);
        too_small   = ratio < (WW+1)'(LOWEST);
        short_main  = main_val < MW'(swallow_val);
        bad         = too_small | short_main;
    end
endmodule

// File: rtl/psd_prescaler.sv
module psd_prescaler
    import psd_pkg::*;
#(
    parameter int unsigned MOD = PRE_MOD
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic clear,
    input  logic swallow,
    output logic wrap
);
    localparam int unsigned CW = $clog2(MOD + 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } pre_t;

    pre_t          pre_d, pre_q;
    logic [CW-1:0] last_val;

    always_comb begin
        last_val = swallow ? CW'(MOD) : CW'(MOD - 1);
        wrap     = run && (pre_q.cnt == last_val);
        pre_d    = pre_q;
        if (clear || wrap) begin
            pre_d.cnt = '0;
        end else begin
            pre_d.cnt = pre_q.cnt + CW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pre_q <= '0;
        end else begin
            pre_q <= pre_d;
        end
    end
endmodule

// File: rtl/psd_swallow_ctr.sv
module psd_swallow_ctr
    import psd_pkg::*;
#(
    parameter int unsigned AW = SWALLOW_W,
    parameter int unsigned MW = MAIN_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          bad,
    input  logic          wrap,
    input  logic [MW-1:0] main_val,
    input  logic [AW-1:0] swallow_val,
    output logic          run,
    output logic          swallow,
    output logic          load,
    output logic          fire
);
    typedef struct packed {
        logic          run;
        logic [MW-1:0] m;
        logic [AW-1:0] a;
    } sw_t;

    sw_t  sw_d, sw_q;
    logic last;

    always_comb begin
        last = sw_q.run && wrap && (sw_q.m == MW'(1));
        load = !bad && (!sw_q.run || last);
        fire = load && sw_q.run;
        sw_d = sw_q;
        if (bad) begin
            sw_d = '0;
        end else if (load) begin
            sw_d.run = 1'b1;
            sw_d.m   = main_val;
            sw_d.a   = swallow_val;
        end else if (wrap) begin
            sw_d.m = sw_q.m - MW'(1);
            if (sw_q.a != '0) begin
                sw_d.a = sw_q.a - AW'(1);
            end
        end
        run     = sw_q.run;
        swallow = (sw_q.a != '0);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sw_q <= '0;
        end else begin
            sw_q <= sw_d;
        end
    end
endmodule

// File: rtl/psd_pulse_gen.sv
module psd_pulse_gen
    import psd_pkg::*;
#(
    parameter int unsigned LEN = PULSE_LEN
) (
    input  logic clk,
    input  logic rst,
    input  logic kill,
    input  logic fire,
    output logic pulse
);
    localparam int unsigned LW = (LEN > 1) ? $clog2(LEN) : 1;

    typedef struct packed {
        logic          on;
        logic [LW-1:0] left;
    } pg_t;

    pg_t pg_d, pg_q;

    always_comb begin
        pg_d = pg_q;
        if (kill) begin
            pg_d = '0;
        end else if (fire) begin
            pg_d.on   = 1'b1;
            pg_d.left = LW'(LEN - 1);
        end else if (pg_q.left != '0) begin
            pg_d.left = pg_q.left - LW'(1);
        end else begin
            pg_d.on = 1'b0;
        end
        pulse = pg_q.on;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pg_q <= '0;
        end else begin
            pg_q <= pg_d;
        end
    end
endmodule

// File: rtl/pswallow_div.sv
module pswallow_div
    import psd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [WORD_W-1:0] ratio_word,
    output logic              pulse_out,
    output logic              ratio_bad
);
    logic [MAIN_W-1:0]    main_val;
    logic [SWALLOW_W-1:0] swallow_val;
    logic                 bad;
    logic                 run;
    logic                 swallow;
    logic                 load;
    logic                 fire;
    logic                 wrap;
    logic                 pre_clear;

    psd_ratio_check #(
        .MOD (PRE_MOD),
        .AW  (SWALLOW_W),
        .MW  (MAIN_W)
    ) u_check (
        .word        (ratio_word),
        .main_val    (main_val),
        .swallow_val (swallow_val),
        .bad         (bad)
    );

    psd_swallow_ctr #(
        .AW (SWALLOW_W),
        .MW (MAIN_W)
    ) u_ctr (
        .clk         (clk),
        .rst         (rst),
        .bad         (bad),
        .wrap        (wrap),
        .main_val    (main_val),
        .swallow_val (swallow_val),
        .run         (run),
        .swallow     (swallow),
        .load        (load),
        .fire        (fire)
    );

    assign pre_clear = bad || load || !run;

    psd_prescaler #(
        .MOD (PRE_MOD)
    ) u_pre (
        .clk     (clk),
        .rst     (rst),
        .run     (run),
        .clear   (pre_clear),
        .swallow (swallow),
        .wrap    (wrap)
    );

    psd_pulse_gen #(
        .LEN (PULSE_LEN)
    ) u_pulse (
        .clk   (clk),
        .rst   (rst),
        .kill  (bad),
        .fire  (fire),
        .pulse (pulse_out)
    );

    assign ratio_bad = bad;
endmodule

// File: rtl/psd_chk.sv
module psd_chk
    import psd_pkg::*;
(
    input logic clk,
    input logic rst,
    input logic pulse_out,
    input logic ratio_bad
);
    localparam int unsigned GW = 16;

    logic [GW-1:0] hi_q;
    logic [GW-1:0] gap_q;
    logic          prev_q;
    logic          seen_q;

    always_ff @(posedge clk) begin
        if (rst || ratio_bad) begin
            hi_q   <= '0;
            gap_q  <= '0;
            prev_q <= 1'b0;
            seen_q <= 1'b0;
        end else begin
            hi_q   <= pulse_out ? hi_q + GW'(1) : '0;
            prev_q <= pulse_out;
            if (pulse_out && !prev_q) begin
                seen_q <= 1'b1;
                gap_q  <= GW'(1);
            end else if (gap_q != '1) begin
                gap_q <= gap_q + GW'(1);
            end
        end
    end

    // R2
    pulse_cap_chk: assert property (@(posedge clk) disable iff (rst)
        hi_q <= GW'(PULSE_LEN));

    // R2
    pulse_full_chk: assert property (@(posedge clk) disable iff (rst)
        (!pulse_out && prev_q) |-> (hi_q == GW'(PULSE_LEN)));

    // R1
    period_floor_chk: assert property (@(posedge clk) disable iff (rst)
        (pulse_out && !prev_q && seen_q) |-> (gap_q >= GW'(MIN_RATIO)));

    // R7
    bad_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        ratio_bad |=> !pulse_out);
endmodule

bind pswallow_div psd_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .pulse_out (pulse_out),
    .ratio_bad (ratio_bad)
);

// File: tb/pswallow_div_tb.sv
module pswallow_div_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [13:0] ratio_word = 14'd100;
    logic        pulse_out;
    logic        ratio_bad;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    pswallow_div u_dut (
        .clk        (clk),
        .rst        (rst),
        .ratio_word (ratio_word),
        .pulse_out  (pulse_out),
        .ratio_bad  (ratio_bad)
    );

    localparam int NV = 10;
    localparam logic [13:0] V_WORD [NV] = '{14'd56, 14'd57, 14'd63, 14'd64, 14'd100,
                                           14'd1000, 14'h3FFF, 14'd55, 14'd0, 14'd49};
    localparam int V_RATIO [NV] = '{56, 57, 63, 64, 100, 1000, 16383, 0, 0, 0};
    localparam bit V_BAD   [NV] = '{0, 0, 0, 0, 0, 0, 0, 1, 1, 1};

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic count_to_rise(output int n, input int limit);
        bit prev;
        prev = pulse_out;
        n = 0;
        while (n < limit) begin
            @(posedge clk); #1;
            n++;
            if (pulse_out && !prev) break;
            prev = pulse_out;
        end
    endtask

    task automatic count_high(output int w);
        w = 1;
        while (w < 64) begin
            @(posedge clk); #1;
            if (!pulse_out) break;
            w++;
        end
    endtask

    task automatic count_highs(input int cycles, output int h);
        h = 0;
        for (int i = 0; i < cycles; i++) begin
            @(posedge clk); #1;
            if (pulse_out) h++;
        end
    endtask

    task automatic restart(input logic [13:0] w);
        @(negedge clk);
        rst = 1'b1;
        ratio_word = w;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        int n, w, h;
        // R4: reset state
        @(posedge clk); #1;
        check(pulse_out == 1'b0, "R4 reset output", pulse_out, 0);

        for (int v = 0; v < NV; v++) begin
            restart(V_WORD[v]);
            check(ratio_bad == V_BAD[v], "R6 flag", ratio_bad, V_BAD[v]);
            if (V_BAD[v]) begin
                count_highs(300, h);
                check(h == 0, "R7 no pulse on bad word", h, 0);
            end else begin
                count_to_rise(n, V_RATIO[v] + 40);
                check(n == V_RATIO[v] + 1, "R3 first pulse latency", n, V_RATIO[v] + 1);
                count_high(w);
                check(w == 8, "R2 pulse width", w, 8);
                count_to_rise(n, V_RATIO[v] + 40);
                check(w + n == V_RATIO[v], "R1 R5 period", w + n, V_RATIO[v]);
            end
        end

        // R8: mid-cycle ratio change
        restart(14'd800);
        count_to_rise(n, 900);
        count_high(w);
        for (int i = 0; i < 10; i++) begin @(posedge clk); #1; end
        ratio_word = 14'd60;
        count_to_rise(n, 900);
        check(w + 10 + n == 800, "R8 cycle in progress kept", w + 10 + n, 800);
        count_high(w);
        count_to_rise(n, 900);
        check(w + n == 60, "R8 new ratio applied", w + n, 60);

        // R7: invalid word during a pulse
        restart(14'd100);
        count_to_rise(n, 200);
        @(posedge clk); #1;
        @(posedge clk); #1;
        check(pulse_out == 1'b1, "R2 pulse still high", pulse_out, 1);
        ratio_word = 14'd50;
        #1;
        check(ratio_bad == 1'b1, "R6 flag combinational", ratio_bad, 1);
        @(posedge clk); #1;
        check(pulse_out == 1'b0, "R7 pulse cut", pulse_out, 0);
        count_highs(300, h);
        check(h == 0, "R7 parked", h, 0);

        // R9: recovery
        ratio_word = 14'd64;
        count_to_rise(n, 200);
        check(n == 65, "R9 restart latency", n, 65);

        // R6: main below swallow flagged
        ratio_word = 14'b00000000101_111;
        #1;
        check(ratio_bad == 1'b1, "R6 M below A", ratio_bad, 1);

        // R4: reset mid-run
        restart(14'd64);
        count_to_rise(n, 200);
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk); #1;
        check(pulse_out == 1'b0, "R4 reset clears pulse", pulse_out, 0);
        count_highs(100, h);
        check(h == 0, "R4 held in reset", h, 0);
        rst = 1'b0;

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(4 * 200000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end
endmodule